// File: doc/BRIEF.md
# SMI Event Status and Enable Registers

This block gathers a set of hardware event pulses into a 16-bit sticky status register and pairs it with a 16-bit enable register. Both registers sit behind a small word-wide I/O port. When any status bit is set and its enable bit is also set, a level System Management Interrupt request is raised. Software services the request by reading the status word and writing ones back to clear the bits it has handled.

A write to a separate command address raises the software event bit. A dedicated strobe sets a global release flag, and that flag raises the BIOS event bit. Clearing the BIOS bit also drops the release flag. A primary-activity pulse can additionally ask the external GP0 timer to reload. The timers, the activity detectors and the ACPI logic all live outside the block and reach it only as single-cycle pulses.

Top module: `smi_evt_ctrl`

## Requirements
- R1: After reset, the status and enable registers read 0000h, and `smi_req_o`, `gbl_rls_o` and `gp0_reload_o` are low.
- R2: A high `hw_evt_i[i]` at a clock edge sets status bit i, for i in 15..10, 7, 6 and 3..0 (15 GPIO range 1, 14 GPIO range 0, 13 GP3 timeout, 12 GP2 timeout, 11 serial-IRQ, 10 sleep-enable write, 7 clock-run resume, 6 primary IRQ resume, 3 legacy USB, 2 GP1 timeout, 1 GP0 timeout, 0 primary activity). A set bit stays set until software clears it. `hw_evt_i` bits 9, 8, 5 and 4 have no effect.
- R3: Bits 9 and 8 always read as 0 in both registers, including after a write of ones to the enable register.
- R4: A write to address 28h clears each status bit whose data bit is 1. Data bits that are 0 leave their status bits unchanged.
- R5: `smi_req_o` is high exactly one clock after a cycle in which some status bit and its matching enable bit are both 1.
- R6: The enable register is read and written at address 28h+2 = 2Ah. Reads at any address other than 28h or 2Ah return 0.
- R7: Any write to address 2Fh sets status bit 5 (software event), whatever the data value.
- R8: A high `gbl_rls_set_i` sets `gbl_rls_o` and status bit 4 at that edge. A write to 28h with data bit 4 set clears both at the same edge. Clearing other status bits leaves `gbl_rls_o` unchanged.
- R9: If a set source and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R10: `gp0_reload_o` is a one-cycle pulse in the clock after `hw_evt_i[0]` is high together with `reload_en_i`. It stays low when `reload_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr_i | input | 1 | Write strobe for the I/O port |
| io_addr_i | input | 8 | I/O byte address of the word |
| io_wdata_i | input | 16 | Write data |
| io_rdata_o | output | 16 | Read data, combinational from `io_addr_i` |
| hw_evt_i | input | 16 | Hardware event pulses, one per status bit |
| reload_en_i | input | 1 | Allows primary activity to request a GP0 reload |
| gbl_rls_set_i | input | 1 | Strobe that sets the global release flag |
| gbl_rls_o | output | 1 | Global release flag |
| smi_req_o | output | 1 | Registered SMI request level |
| gp0_reload_o | output | 1 | GP0 timer reload pulse |

## Verification
The assertions assume that the event inputs, the write strobe and the release strobe are synchronous single-cycle pulses. They also assume that no port access is made while the internal synchronized reset is still low. The stimulus drives every input just after a rising edge and holds each pulse for exactly one cycle. It waits several cycles after reset is released before the first access. Collisions between a set source and a clear are created on purpose only in the directed set-versus-clear tests.

// File: rtl/smi_evt_pkg.sv
package smi_evt_pkg;
  localparam int unsigned DATA_W = 16;
  localparam logic [DATA_W-1:0] RSVD_MASK = 16'h0300;
  localparam logic [DATA_W-1:0] HW_MASK   = 16'hFCCF;
  localparam int unsigned BIT_SW   = 5;
  localparam int unsigned BIT_BIOS = 4;
  localparam int unsigned BIT_ACT  = 0;
endpackage

// File: rtl/smi_rst_sync.sv
module smi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end
  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/smi_sts_bank.sv
module smi_sts_bank #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RSVD[i]) begin : g_rsvd
      assign sts_o[i] = 1'b0;
    end else begin : g_live
      logic q, d;
      // set has priority over clear
      always_comb d = set_i[i] | (q & ~clr_i[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= d;
      end
      assign sts_o[i] = q;
    end
  end
endmodule

// File: rtl/smi_en_reg.sv
module smi_en_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q, en_d;
  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i & ~RSVD;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end
  assign en_o = en_q;
endmodule

// File: rtl/smi_out_regs.sv
module smi_out_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] en_i,
  input  logic         act_evt_i,
  input  logic         reload_en_i,
  output logic         smi_o,
  output logic         reload_o
);
  logic smi_q, smi_d, rld_q, rld_d;
  always_comb begin
    smi_d = |(sts_i & en_i);
    rld_d = act_evt_i & reload_en_i;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q <= 1'b0;
      rld_q <= 1'b0;
    end else begin
      smi_q <= smi_d;
      rld_q <= rld_d;
    end
  end
  assign smi_o    = smi_q;
  assign reload_o = rld_q;
endmodule

// File: rtl/smi_evt_ctrl.sv
module smi_evt_ctrl #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h28,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h2A,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h2F
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              io_wr_i,
  input  logic [ADDR_W-1:0]                 io_addr_i,
  input  logic [smi_evt_pkg::DATA_W-1:0]    io_wdata_i,
  output logic [smi_evt_pkg::DATA_W-1:0]    io_rdata_o,
  input  logic [smi_evt_pkg::DATA_W-1:0]    hw_evt_i,
  input  logic                              reload_en_i,
  input  logic                              gbl_rls_set_i,
  output logic                              gbl_rls_o,
  output logic                              smi_req_o,
  output logic                              gp0_reload_o
);
  import smi_evt_pkg::*;
  localparam int unsigned W = DATA_W;

  logic         rst_sync_n;
  logic         sts_wr, en_wr, cmd_wr;
  logic [W-1:0] set_vec, clr_vec, sts_q, en_q;
  logic         rls_q, rls_d;

  smi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  always_comb begin
    sts_wr = io_wr_i && (io_addr_i == STS_ADDR);
    en_wr  = io_wr_i && (io_addr_i == EN_ADDR);
    cmd_wr = io_wr_i && (io_addr_i == CMD_ADDR);
    set_vec = hw_evt_i & HW_MASK;
    set_vec[BIT_SW]   = cmd_wr;
    set_vec[BIT_BIOS] = gbl_rls_set_i;
    clr_vec = sts_wr ? io_wdata_i : '0;
  end

  smi_sts_bank #(.W(W), .RSVD(RSVD_MASK)) u_sts (
    .clk(clk), .rst_n(rst_sync_n), .set_i(set_vec), .clr_i(clr_vec), .sts_o(sts_q)
  );

  smi_en_reg #(.W(W), .RSVD(RSVD_MASK)) u_en (
    .clk(clk), .rst_n(rst_sync_n), .wr_i(en_wr), .wdata_i(io_wdata_i), .en_o(en_q)
  );

  // release flag: strobe sets, clearing the BIOS status bit clears
  always_comb begin
    rls_d = rls_q;
    if (gbl_rls_set_i)         rls_d = 1'b1;
    else if (clr_vec[BIT_BIOS]) rls_d = 1'b0;
  end
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rls_q <= 1'b0;
    else             rls_q <= rls_d;
  end
  assign gbl_rls_o = rls_q;

  smi_out_regs #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .sts_i(sts_q), .en_i(en_q),
    .act_evt_i(hw_evt_i[BIT_ACT]), .reload_en_i(reload_en_i),
    .smi_o(smi_req_o), .reload_o(gp0_reload_o)
  );

  always_comb begin
    if (io_addr_i == STS_ADDR)     io_rdata_o = sts_q;
    else if (io_addr_i == EN_ADDR) io_rdata_o = en_q;
    else                           io_rdata_o = '0;
  end
endmodule

// File: rtl/smi_evt_chk.sv
module smi_evt_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STS_ADDR = 8'h28,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h2F
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              io_wr_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [15:0]       io_wdata_i,
  input logic [15:0]       hw_evt_i,
  input logic              reload_en_i,
  input logic              gbl_rls_set_i,
  input logic              gbl_rls_o,
  input logic              smi_req_o,
  input logic              gp0_reload_o,
  input logic [15:0]       sts_q,
  input logic [15:0]       en_q
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sts_q[9:8] == 2'b00) && (en_q[9:8] == 2'b00)); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(io_wr_i && io_addr_i == STS_ADDR) |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((sts_q & $past(hw_evt_i & 16'hFCCF)) == $past(hw_evt_i & 16'hFCCF))); // R9
  AST_SMI_RISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(sts_q & en_q)) |=> smi_req_o); // R5
  AST_SMI_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(|(sts_q & en_q)) |=> !smi_req_o); // R5
  AST_CMD_SW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr_i && io_addr_i == CMD_ADDR) |=> sts_q[5]); // R7
  AST_RLS_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr_i && io_addr_i == STS_ADDR && io_wdata_i[4] && !gbl_rls_set_i) |=> (!gbl_rls_o && !sts_q[4])); // R8
  AST_RLS_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gbl_rls_set_i |=> (gbl_rls_o && sts_q[4])); // R8
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hw_evt_i[0] && reload_en_i) |=> gp0_reload_o); // R10
  AST_RELOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hw_evt_i[0] && reload_en_i) |=> !gp0_reload_o); // R10
endmodule

bind smi_evt_ctrl smi_evt_chk #(.ADDR_W(ADDR_W), .STS_ADDR(STS_ADDR), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .io_wr_i(io_wr_i), .io_addr_i(io_addr_i),
  .io_wdata_i(io_wdata_i), .hw_evt_i(hw_evt_i), .reload_en_i(reload_en_i),
  .gbl_rls_set_i(gbl_rls_set_i), .gbl_rls_o(gbl_rls_o), .smi_req_o(smi_req_o),
  .gp0_reload_o(gp0_reload_o), .sts_q(sts_q), .en_q(en_q)
);

// File: tb/smi_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module smi_evt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr;
  logic [7:0]  io_addr;
  logic [15:0] io_wdata, io_rdata, hw_evt;
  logic        reload_en, rls_set, rls, smi, rld;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  smi_evt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .io_wr_i(io_wr), .io_addr_i(io_addr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .hw_evt_i(hw_evt),
    .reload_en_i(reload_en), .gbl_rls_set_i(rls_set), .gbl_rls_o(rls),
    .smi_req_o(smi), .gp0_reload_o(rld)
  );

  // {enable written, event pulse, expected status, expected smi}
  localparam logic [48:0] VEC [8] = '{
    {16'h0000, 16'h0001, 16'h0001, 1'b0},
    {16'h0001, 16'h0001, 16'h0001, 1'b1},
    {16'hFFFF, 16'h0300, 16'h0000, 1'b0},
    {16'h8000, 16'hC000, 16'hC000, 1'b1},
    {16'h3CFF, 16'h0C00, 16'h0C00, 1'b1},
    {16'h00FF, 16'hFF00, 16'hFC00, 1'b0},
    {16'hFFFF, 16'h00EF, 16'h00CF, 1'b1},
    {16'h0030, 16'hFFFF, 16'hFCCF, 1'b0}
  };

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [15:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    tick();
    io_wr = 1'b0; io_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    io_addr = a; #0.5; d = io_rdata;
  endtask

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; io_wr = 1'b0; io_addr = 8'h28; io_wdata = '0;
    hw_evt = '0; reload_en = 1'b0; rls_set = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // reset state
    rd(8'h28, v); chk("R1 status", v, 16'h0000);
    rd(8'h2A, v); chk("R1 enable", v, 16'h0000);
    chk("R1 outputs", {13'd0, smi, rls, rld}, 16'h0000);

    // vector table
    for (int k = 0; k < 8; k++) begin
      io_write(8'h2A, VEC[k][48:33]);
      rd(8'h2A, v); chk("R6/R3 enable readback", v, VEC[k][48:33] & 16'hFCFF);
      hw_evt = VEC[k][32:17];
      tick();
      hw_evt = '0;
      rd(8'h28, v); chk("R2 status", v, VEC[k][16:1]);
      tick();
      chk("R5 smi", {15'd0, smi}, {15'd0, VEC[k][0]});
      io_write(8'h28, 16'hFFFF);
      rd(8'h28, v); chk("R4 clear all", v, 16'h0000);
      tick();
    end

    // unmapped read
    rd(8'h30, v); chk("R6 unmapped read", v, 16'h0000);

    // write zero has no effect, partial clear
    hw_evt = 16'h8006; tick(); hw_evt = '0;
    io_write(8'h28, 16'h0000);
    rd(8'h28, v); chk("R4 write zero", v, 16'h8006);
    io_write(8'h28, 16'h0004);
    rd(8'h28, v); chk("R4 partial clear", v, 16'h8002);

    // set wins over clear
    hw_evt = 16'h0002; io_wr = 1'b1; io_addr = 8'h28; io_wdata = 16'h8002;
    tick();
    hw_evt = '0; io_wr = 1'b0; io_wdata = '0;
    rd(8'h28, v); chk("R9 set wins", v, 16'h0002);
    io_write(8'h28, 16'hFFFF);

    // command port sets software bit regardless of data
    io_write(8'h2F, 16'h0000);
    rd(8'h28, v); chk("R7 cmd sets sw bit", v, 16'h0020);
    io_write(8'h28, 16'h0020);

    // release flag
    rls_set = 1'b1; tick(); rls_set = 1'b0;
    rd(8'h28, v); chk("R8 bios bit set", v, 16'h0010);
    chk("R8 rls set", {15'd0, rls}, 16'h0001);
    hw_evt = 16'h0008; tick(); hw_evt = '0;
    io_write(8'h28, 16'h0008);
    chk("R8 rls kept on other clear", {15'd0, rls}, 16'h0001);
    io_write(8'h28, 16'h0010);
    rd(8'h28, v); chk("R8 bios cleared", v, 16'h0000);
    chk("R8 rls cleared", {15'd0, rls}, 16'h0000);

    // GP0 reload pulse
    reload_en = 1'b1; hw_evt = 16'h0001; tick(); hw_evt = '0;
    chk("R10 reload pulse", {15'd0, rld}, 16'h0001);
    tick();
    chk("R10 reload one cycle", {15'd0, rld}, 16'h0000);
    reload_en = 1'b0; hw_evt = 16'h0001; tick(); hw_evt = '0;
    chk("R10 no reload when disabled", {15'd0, rld}, 16'h0000);
    io_write(8'h28, 16'hFFFF);

    // smi latency on enable write
    io_write(8'h2A, 16'h0000);
    hw_evt = 16'h0400; tick(); hw_evt = '0;
    io_write(8'h2A, 16'h0400);
    chk("R5 smi not yet", {15'd0, smi}, 16'h0000);
    tick();
    chk("R5 smi one clock later", {15'd0, smi}, 16'h0001);

    // reset again
    rst_n = 1'b0; #1;
    rd(8'h2A, v); chk("R1 enable after reset", v, 16'h0000);
    chk("R1 smi after reset", {15'd0, smi}, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule